// File: doc/BRIEF.md
# GPIO Runtime Register Bank

This block is the runtime register window of a general-purpose I/O unit with 29 pins grouped into four byte-wide ports. Software reaches it through a 4-bit byte offset inside a 16-byte I/O region. Each port has an output data register, which reads back, and an input data register, which shows the synchronized pad levels. The two lower ports also have an event-enable and an event-status register. These let a rising edge on an input raise a sticky flag and an interrupt.

Per-pin output-enable, push-pull and pull-up controls come from a separate configuration block. The bank combines them with the output data to decide whether each pad is driven and at what level. It also decides whether an undriven pad should be pulled up. Register reads are combinational on the offset. Writes take effect at the clock edge on which the write strobe is high.

Top module: `gpio_rt_bank`

## Requirements
- R1: Port 0 decodes output data at offset 0x0, input data at 0x1, event enable at 0x2 and event status at 0x3. Port 1 uses 0x4, 0x5, 0x6 and 0x7 for the same four registers. Output data and event enable registers read back the last value written.
- R2: Port 2 has output data at 0x8 and input data at 0x9. Port 3 has output data at 0xA and input data at 0xB. Bits 7:5 of both port-3 registers read as zero. Offsets 0xC to 0xF read as zero and writes to them change nothing.
- R3: Pin n sits in port n/8 at bit n%8 for every n from 0 to 28. Writing one pin's bit leaves every other pin's output bit unchanged.
- R4: An input data register shows pad_in through a two-flop synchronizer. A pad change made before clock edge k is readable after edge k+1 and not after edge k. Writes to input data offsets are ignored.
- R5: pad_oe of a pin is 1 only when its output-enable control is 1. In push-pull mode (pp=1) the pin drives its output bit. In open-drain mode (pp=0) it drives only when its output bit is 0. pad_do is the output bit in push-pull mode and 0 in open-drain mode.
- R6: pad_pu of a pin is 1 when its pull-up control is 1 and the pin is not driven.
- R7: An event-status bit of pins 0 to 15 sets on a rising edge of the synchronized input while its enable bit is 1. A falling edge, or a rising edge while the enable bit is 0, sets nothing.
- R8: Writing 1 to an event-status bit clears it. Writing 0 leaves it unchanged. A new edge in the same cycle as a clear wins.
- R9: irq is 1 exactly when some event-status bit is 1 and its enable bit is also 1. Clearing the enable bit drops irq but keeps the status bit.
- R10: After reset every register reads as zero and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Byte offset in the register window |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| pin_oe_cfg | input | NPINS | Per-pin output-enable control |
| pin_pp_cfg | input | NPINS | Per-pin push-pull (1) or open-drain (0) control |
| pin_pu_cfg | input | NPINS | Per-pin pull-up control |
| pad_in | input | NPINS | Pad levels seen at the pins |
| pad_oe | output | NPINS | Pad driver enable |
| pad_do | output | NPINS | Pad driven level |
| pad_pu | output | NPINS | Pad pull-up enable |
| irq | output | 1 | OR of enabled pending events |

## Verification
The assertions check on every cycle that no pad drives without its enable and that pull-up and drive never coincide. They also check that the unused offsets read zero and that enable writes land a cycle later. Further cycle checks cover the absence of event flags on disabled pins, clears with no competing edge, and irq only with a pending flag. Some behaviour can only be shown by the bench scenarios. These are the exact pin-to-bit mapping across all 29 pins, the two-cycle input latency and the read-only input registers. They also include the full drive table across every control combination, and the masking, retention and clearing sequences of events.

// File: rtl/gpio_rt_bank.sv
module gpio_rt_bank #(
  parameter int NPINS  = 29,
  parameter int EVPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [NPINS-1:0] pin_oe_cfg,
  input  logic [NPINS-1:0] pin_pp_cfg,
  input  logic [NPINS-1:0] pin_pu_cfg,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_do,
  output logic [NPINS-1:0] pad_pu,
  output logic             irq
);

  function automatic logic [3:0] out_ofs(int port);
    return (port < 2) ? 4'(port * 4) : 4'(8 + (port - 2) * 2);
  endfunction

  function automatic logic [3:0] evt_ofs(int port, int sel);
    return 4'(port * 4 + 2 + sel);
  endfunction

  logic [NPINS-1:0]  dout_q, dout_nx;
  logic [NPINS-1:0]  s1_q, s2_q;
  logic [EVPINS-1:0] s3_q, rise, even_q, even_nx, evst_q, clr;

  always_comb begin
    dout_nx = dout_q;
    for (int i = 0; i < NPINS; i++)
      if (reg_wr && reg_addr == out_ofs(i / 8))
        dout_nx[i] = reg_wdata[i % 8];
  end

  always_comb begin
    even_nx = even_q;
    clr     = '0;
    for (int i = 0; i < EVPINS; i++) begin
      if (reg_wr && reg_addr == evt_ofs(i / 8, 0))
        even_nx[i] = reg_wdata[i % 8];
      if (reg_wr && reg_addr == evt_ofs(i / 8, 1))
        clr[i] = reg_wdata[i % 8];
    end
  end

  assign rise = s2_q[EVPINS-1:0] & ~s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      s3_q   <= '0;
      even_q <= '0;
      evst_q <= '0;
    end else begin
      dout_q <= dout_nx;
      s1_q   <= pad_in;
      s2_q   <= s1_q;
      s3_q   <= s2_q[EVPINS-1:0];
      even_q <= even_nx;
      evst_q <= (evst_q & ~clr) | (rise & even_q);
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (reg_addr == out_ofs(i / 8))
        reg_rdata[i % 8] = dout_q[i];
      if (reg_addr == out_ofs(i / 8) + 4'd1)
        reg_rdata[i % 8] = s2_q[i];
    end
    for (int i = 0; i < EVPINS; i++) begin
      if (reg_addr == evt_ofs(i / 8, 0))
        reg_rdata[i % 8] = even_q[i];
      if (reg_addr == evt_ofs(i / 8, 1))
        reg_rdata[i % 8] = evst_q[i];
    end
  end

  assign pad_oe = pin_oe_cfg & (pin_pp_cfg | ~dout_q);
  assign pad_do = dout_q & pin_pp_cfg;
  assign pad_pu = pin_pu_cfg & ~pad_oe;
  assign irq    = |(evst_q & even_q);

endmodule

// File: rtl/gpio_rt_bank_chk.sv
module gpio_rt_bank_chk #(
  parameter int NPINS  = 29,
  parameter int EVPINS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        reg_addr,
  input logic              reg_wr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic [NPINS-1:0]  pin_oe_cfg,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_pu,
  input logic              irq,
  input logic [EVPINS-1:0] even_q,
  input logic [EVPINS-1:0] evst_q,
  input logic [EVPINS-1:0] rise
);

  // R5
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~pin_oe_cfg) == '0);

  // R6
  pull_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  // R2
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr >= 4'hC |-> reg_rdata == 8'h00);

  // R1
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 4'h2 |=> even_q[7:0] == $past(reg_wdata));

  // R7
  masked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (evst_q & ~$past(evst_q) & ~$past(even_q)) == '0);

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 4'h3 && reg_wdata == 8'hFF && rise[7:0] == 8'h00
    |=> evst_q[7:0] == 8'h00);

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> evst_q != '0);

endmodule

bind gpio_rt_bank gpio_rt_bank_chk #(.NPINS(NPINS), .EVPINS(EVPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_oe_cfg(pin_oe_cfg),
  .pad_oe(pad_oe), .pad_pu(pad_pu), .irq(irq), .even_q(even_q),
  .evst_q(evst_q), .rise(rise)
);

// File: tb/gpio_rt_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_rt_bank_tb_top;
  localparam int NP = 29;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [NP-1:0] oe_c = '0, pp_c = '0, pu_c = '0, pad_in = '0;
  logic [NP-1:0] pad_oe, pad_do, pad_pu;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_rt_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_oe_cfg(oe_c),
    .pin_pp_cfg(pp_c), .pin_pu_cfg(pu_c), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu), .irq(irq));

  function automatic logic [3:0] oa(int p);
    return (p < 2) ? 4'(p * 4) : 4'(8 + (p - 2) * 2);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdchk(logic [3:0] a, logic [7:0] exp, string tag);
    reg_addr = a;
    #0.5;
    chk(reg_rdata == exp, tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] shadow;

  initial begin
    #200000;
    chk(1'b0, "WATCHDOG", 0, 1);
    done = 1;
  end

  initial begin
    waitc(3);
    rst_n = 1'b1;
    waitc(1);
    // R10 reset state
    for (int a = 0; a < 16; a++) rdchk(4'(a), 8'h00, "R10 reset read");
    chk(irq == 1'b0, "R10 irq", 32'(irq), 0);

    // R3 / R1 / R2 single-pin sweep with read-modify-write
    shadow = '0;
    for (int n = 0; n < NP; n++) begin
      reg_addr = oa(n / 8); #0.5;
      wr(oa(n / 8), reg_rdata | 8'(1 << (n % 8)));
      shadow[n] = 1'b1;
      for (int p = 0; p < 4; p++)
        rdchk(oa(p), 8'(shadow >> (8 * p)), "R3 pin map");
    end
    for (int n = 0; n < NP; n++) begin
      reg_addr = oa(n / 8); #0.5;
      wr(oa(n / 8), reg_rdata & ~8'(1 << (n % 8)));
      shadow[n] = 1'b0;
      rdchk(oa(n / 8), 8'(shadow >> (8 * (n / 8))), "R3 pin clear");
    end
    wr(4'hA, 8'hFF);
    rdchk(4'hA, 8'h1F, "R2 port3 upper bits");
    wr(4'h0, 8'hA5); wr(4'h4, 8'h3C); wr(4'h8, 8'h96);
    rdchk(4'h0, 8'hA5, "R1 port0 out"); rdchk(4'h4, 8'h3C, "R1 port1 out");
    rdchk(4'h8, 8'h96, "R2 port2 out");
    for (int a = 12; a < 16; a++) begin
      wr(4'(a), 8'hFF);
      rdchk(4'(a), 8'h00, "R2 hole");
    end
    rdchk(4'h0, 8'hA5, "R2 hole write no effect");
    wr(4'h1, 8'hFF); wr(4'h9, 8'hFF);
    rdchk(4'h1, 8'h00, "R4 din read-only p0");
    rdchk(4'h9, 8'h00, "R4 din read-only p2");

    // R4 synchronizer latency per pin
    for (int n = 0; n < NP; n++) begin
      @(negedge clk);
      pad_in = NP'(1) << n;
      @(negedge clk);
      rdchk(oa(n / 8) + 4'd1, (n > 0 && (n - 1) / 8 == n / 8) ? 8'(1 << ((n - 1) % 8)) : 8'h00, "R4 one edge old");
      @(negedge clk);
      rdchk(oa(n / 8) + 4'd1, 8'(1 << (n % 8)), "R4 two edges new");
    end
    pad_in = '0;
    pad_in[28:24] = 5'h1F;
    waitc(3);
    rdchk(4'hB, 8'h1F, "R2 port3 din upper zero");
    pad_in = '0;
    waitc(4);

    // R5 / R6 drive table across all control combinations
    for (int c = 0; c < 16; c++) begin
      oe_c = c[0] ? '1 : '0;
      pp_c = c[1] ? '1 : '0;
      pu_c = c[2] ? '1 : '0;
      for (int p = 0; p < 4; p++) wr(oa(p), c[3] ? 8'hFF : 8'h00);
      #0.5;
      begin
        logic drv;
        drv = c[0] && (c[1] || !c[3]);
        chk(pad_oe == (drv ? '1 : '0), "R5 pad_oe", 32'(pad_oe), drv ? '1 : 0);
        chk(pad_do == ((c[1] && c[3]) ? '1 : '0), "R5 pad_do", 32'(pad_do), 32'(c));
        chk(pad_pu == ((c[2] && !drv) ? '1 : '0), "R6 pad_pu", 32'(pad_pu), 32'(c));
      end
    end
    oe_c = 29'h0F0F0F0F; pp_c = 29'h00FF00FF; pu_c = '1;
    wr(4'h0, 8'h33); wr(4'h4, 8'h33); wr(4'h8, 8'h33); wr(4'hA, 8'h13);
    #0.5;
    begin
      logic [NP-1:0] d, e;
      d = 29'h13333333;
      e = oe_c & (pp_c | ~d);
      chk(pad_oe == e, "R5 mixed oe", 32'(pad_oe), 32'(e));
      chk(pad_do == (d & pp_c), "R5 mixed do", 32'(pad_do), 32'(d & pp_c));
      chk(pad_pu == ~e, "R6 mixed pu", 32'(pad_pu), 32'(~e));
    end

    // R7 / R9 events
    wr(4'h2, 8'h55); wr(4'h6, 8'hAA);
    rdchk(4'h2, 8'h55, "R1 en p0"); rdchk(4'h6, 8'hAA, "R1 en p1");
    chk(irq == 1'b0, "R9 idle irq", 32'(irq), 0);
    pad_in[15:0] = 16'hFFFF;
    waitc(4);
    rdchk(4'h3, 8'h55, "R7 status p0"); rdchk(4'h7, 8'hAA, "R7 status p1");
    chk(irq == 1'b1, "R9 irq set", 32'(irq), 1);
    // R8 partial clear, zero write
    wr(4'h3, 8'h05);
    rdchk(4'h3, 8'h50, "R8 w1c partial");
    wr(4'h3, 8'h00);
    rdchk(4'h3, 8'h50, "R8 write zero");
    wr(4'h3, 8'hFF); wr(4'h7, 8'hFF);
    rdchk(4'h3, 8'h00, "R8 clear p0"); rdchk(4'h7, 8'h00, "R8 clear p1");
    chk(irq == 1'b0, "R9 irq cleared", 32'(irq), 0);
    pad_in[15:0] = 16'h0000;
    waitc(4);
    rdchk(4'h3, 8'h00, "R7 falling no set");
    rdchk(4'h7, 8'h00, "R7 falling no set p1");
    // R9 mask drop keeps status
    pad_in[15:0] = 16'h0101;
    waitc(4);
    rdchk(4'h3, 8'h01, "R7 single rise");
    rdchk(4'h7, 8'h00, "R7 masked rise");
    wr(4'h2, 8'h00);
    chk(irq == 1'b0, "R9 irq masked", 32'(irq), 0);
    rdchk(4'h3, 8'h01, "R9 status kept");
    wr(4'h2, 8'h01);
    chk(irq == 1'b1, "R9 irq reenabled", 32'(irq), 1);

    done = 1;
  end

  initial begin
    wait (done);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule